// File: doc/BRIEF.md
# Dual-Word NCO with Quadrant Phase Select

This block is a numerically controlled oscillator that produces a 14-bit signed sine code on every clock. It builds its per-clock phase step from two 48-bit tuning words, a center word and an offset word. Each word can be gated to zero: the center word by a synchronous control bit, and the offset word by an asynchronous enable pin that is resynchronised inside. Gating only the offset word gives binary frequency keying with a fixed latency. A 48-bit accumulator integrates the step. The top of the accumulated phase addresses a quarter-wave sine table. Two asynchronous pins add 0, 90, 180 or 270 degrees before the lookup, which supports phase keying or a sine/cosine pair built from two instances.

A run bit holds the accumulator at zero while it is low. Two instances that release the bit on the same edge therefore start from a known phase relationship. The 16-bit table amplitude is rounded to 14 bits. Pipeline padding fixes the latency of each control path. A two-state sequencer, HOLD and RUN, forces the output to zero after reset until the pipeline has filled. Its transitions are: reset goes to HOLD, HOLD goes to RUN once the settle count expires, and RUN stays in RUN until the next reset.

Top module: `nco_dual_word`

## Requirements
- R1: The phase step is (center term + offset term) mod 2^48, where each term is its word or zero. A sum that carries past bit 47 wraps. For example, 4000_0000_0000h plus C000_0000_0000h gives a step of zero and a constant output.
- R2: While `offset_en` (synchronised) is low, the offset term is zero and `offset_word` has no effect on `nco_out`.
- R3: While `center_en` is low, the center term is zero and `center_word` has no effect on `nco_out`.
- R4: The accumulator is 48 bits wide and adds the step on every edge. Accumulator bit 47 weighs 180 degrees. Only accumulator bits 47:36 address the table, so lower bits act only through carries.
- R5: The 12-bit lookup phase p gives amplitude A = ±round(32767·sin(2π(i+0.5)/4096)). Here i = p[9:0] in quadrants 0 and 2, and i = 1023 − p[9:0] in quadrants 1 and 3. A is negative in quadrants 2 and 3, where the quadrant is p[11:10].
- R6: `quad_sel` q adds q·1024 to p modulo 4096, i.e. q·90 degrees. A change of `quad_sel` set up before edge k appears in `nco_out` after edge k+11.
- R7: `nco_out` is the two's-complement code floor((A+2)/4), clamped to at most 8191. The smallest code is −8192 (2000h).
- R8: While `acc_run` is low the accumulator holds zero. If `acc_run` is low at edge e0 and high afterwards, with a constant step s, then `nco_out` after edge e0+10+j equals the code for phase j·s.
- R9: A change of `offset_en` set up before edge k first affects `nco_out` after edge k+13, which is the fourteenth edge.
- R10: `nco_out` is zero during reset and after each of the first 10 edges after release. After the 11th edge it shows the pipeline value (HOLD to RUN).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| center_word | input | 48 | Center tuning word |
| offset_word | input | 48 | Offset tuning word |
| center_en | input | 1 | Synchronous gate for the center word; low zeros it |
| offset_en | input | 1 | Asynchronous gate for the offset word; low zeros it |
| quad_sel | input | 2 | Asynchronous quadrant phase select (q·90 degrees) |
| acc_run | input | 1 | Synchronous; low clears and holds the accumulator |
| nco_out | output | 14 | Two's-complement sine code |

## Verification
Each path is checked at its own latency. A change of the offset enable is due after 14 edges, a change of the quadrant select after 12 edges, and the first non-forced output after the 11th edge past reset release. Samples after an accumulator restart are due 10 edges after the clearing edge, plus one edge per step. The bench applies inputs on falling edges, counts rising edges from the edge that first captures the change, and compares on the falling edge just before and just after the edge where the change is due. This confirms that the change arrives neither early nor late.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;

    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } nco_state_e;

    // Magnitude of one quarter-wave sample, taken at the middle of its
    // phase bin so that the four quadrants mirror exactly.
    function automatic int quarter_mag(input int idx, input int addr_w, input int amp_w);
        real pi_v;
        real full_v;
        real ang_v;
        pi_v   = 3.14159265358979;
        full_v = real'((1 << (amp_w - 1)) - 1);
        ang_v  = 2.0 * pi_v * (real'(idx) + 0.5) / real'(4 << addr_w);
        return $rtoi(full_v * $sin(ang_v) + 0.5);
    endfunction

endpackage

// File: rtl/nco_sync.sv
`timescale 1ns/1ps
module nco_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/nco_incr.sv
`timescale 1ns/1ps
module nco_incr #(
    parameter int ACC_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] center_word,
    input  logic [ACC_W-1:0] offset_word,
    input  logic             center_en,
    input  logic             offset_en_s,
    output logic [ACC_W-1:0] inc_q
);

    logic [ACC_W-1:0] center_term;
    logic [ACC_W-1:0] offset_term;

    always_comb begin
        center_term = center_en   ? center_word : '0;
        offset_term = offset_en_s ? offset_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inc_q <= '0;
        else        inc_q <= center_term + offset_term;
    end

endmodule

// File: rtl/nco_phase.sv
`timescale 1ns/1ps
module nco_phase #(
    parameter int ACC_W = 48,
    parameter int LKP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_run,
    input  logic [ACC_W-1:0] inc,
    input  logic [1:0]       quad_s,
    output logic [ACC_W-1:0] acc_q,
    output logic [LKP_W-1:0] ph_q
);

    localparam int QPAD = LKP_W - 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            ph_q  <= '0;
        end else begin
            acc_q <= acc_run ? (acc_q + inc) : '0;
            ph_q  <= acc_q[ACC_W-1 -: LKP_W] + {quad_s, {QPAD{1'b0}}};
        end
    end

endmodule

// File: rtl/nco_sine.sv
`timescale 1ns/1ps
module nco_sine #(
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 16,
    parameter int OUT_W  = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W+1:0]       ph,
    output logic signed [AMP_W-1:0] amp_q,
    output logic [OUT_W-1:0]        code_q
);

    localparam int QN       = 1 << ADDR_W;
    localparam int SH       = AMP_W - OUT_W;
    localparam int HALF     = 1 << (SH - 1);
    localparam logic signed [OUT_W:0] CMAX = (OUT_W+1)'((1 << (OUT_W - 1)) - 1);

    logic [AMP_W-2:0] qtab [QN];

    for (genvar g = 0; g < QN; g++) begin : g_rom
        localparam logic [AMP_W-2:0] VAL = (AMP_W-1)'(nco_pkg::quarter_mag(g, ADDR_W, AMP_W));
        assign qtab[g] = VAL;
    end

    logic [1:0]              quad;
    logic [ADDR_W-1:0]       sub;
    logic [ADDR_W-1:0]       idx;
    logic signed [AMP_W-1:0] mag;
    logic signed [AMP_W-1:0] amp_d;

    always_comb begin
        quad  = ph[ADDR_W+1:ADDR_W];
        sub   = ph[ADDR_W-1:0];
        idx   = quad[0] ? ~sub : sub;
        mag   = $signed({1'b0, qtab[idx]});
        amp_d = quad[1] ? -mag : mag;
    end

    logic signed [AMP_W:0]   biased;
    logic signed [OUT_W:0]   shifted;
    logic [OUT_W-1:0]        code_d;

    always_comb begin
        biased  = $signed({amp_q[AMP_W-1], amp_q}) + (AMP_W+1)'(HALF);
        shifted = (OUT_W+1)'(biased >>> SH);
        code_d  = (shifted > CMAX) ? CMAX[OUT_W-1:0] : shifted[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            amp_q  <= '0;
            code_q <= '0;
        end else begin
            amp_q  <= amp_d;
            code_q <= code_d;
        end
    end

endmodule

// File: rtl/nco_dual_word.sv
`timescale 1ns/1ps
module nco_dual_word #(
    parameter int ACC_W   = 48,
    parameter int ADDR_W  = 10,
    parameter int AMP_W   = 16,
    parameter int OUT_W   = 14,
    parameter int OFS_LAT = 14,
    parameter int RST_LAT = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [47:0]      center_word,
    input  logic [47:0]      offset_word,
    input  logic             center_en,
    input  logic             offset_en,
    input  logic [1:0]       quad_sel,
    input  logic             acc_run,
    output logic [13:0]      nco_out
);

    import nco_pkg::*;

    localparam int LKP_W  = ADDR_W + 2;
    localparam int FIXED  = 8;
    localparam int PAD_N  = OFS_LAT - FIXED;
    localparam int CNT_W  = $clog2(RST_LAT);

    // pin resynchronisation: {offset enable, quadrant select}
    logic [2:0] pins_s;
    logic       oe_s;
    logic [1:0] quad_s;

    nco_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({offset_en, quad_sel}),
        .q     (pins_s)
    );

    assign oe_s   = pins_s[2];
    assign quad_s = pins_s[1:0];

    logic [ACC_W-1:0] inc_q;

    nco_incr #(.ACC_W(ACC_W)) u_incr (
        .clk         (clk),
        .rst_n       (rst_n),
        .center_word (center_word),
        .offset_word (offset_word),
        .center_en   (center_en),
        .offset_en_s (oe_s),
        .inc_q       (inc_q)
    );

    logic [ACC_W-1:0] acc_q;
    logic [LKP_W-1:0] ph_q;

    nco_phase #(.ACC_W(ACC_W), .LKP_W(LKP_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_run (acc_run),
        .inc     (inc_q),
        .quad_s  (quad_s),
        .acc_q   (acc_q),
        .ph_q    (ph_q)
    );

    logic signed [AMP_W-1:0] amp_q;
    logic [OUT_W-1:0]        code_q;

    nco_sine #(.ADDR_W(ADDR_W), .AMP_W(AMP_W), .OUT_W(OUT_W)) u_sine (
        .clk    (clk),
        .rst_n  (rst_n),
        .ph     (ph_q),
        .amp_q  (amp_q),
        .code_q (code_q)
    );

    // latency padding so the offset-enable path totals OFS_LAT registers
    logic [OUT_W-1:0] pad [PAD_N+1];
    assign pad[0] = code_q;

    for (genvar k = 1; k <= PAD_N; k++) begin : g_pad
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pad[k] <= '0;
            else        pad[k] <= pad[k-1];
        end
    end

    // settle sequencer
    nco_state_e       state_q;
    nco_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             out_gate;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (cnt_q == CNT_W'(RST_LAT - 2)) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_HOLD) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        out_gate = 1'b0;
        unique case (state_q)
            ST_HOLD: out_gate = 1'b0;
            ST_RUN:  out_gate = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nco_out <= '0;
        else        nco_out <= out_gate ? pad[PAD_N] : '0;
    end

endmodule

// File: rtl/nco_dual_word_chk.sv
`timescale 1ns/1ps
module nco_dual_word_chk #(
    parameter int ACC_W   = 48,
    parameter int AMP_W   = 16,
    parameter int OUT_W   = 14,
    parameter int RST_LAT = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_run,
    input  logic                    center_en,
    input  logic                    oe_s,
    input  logic [ACC_W-1:0]        inc_q,
    input  logic [ACC_W-1:0]        acc_q,
    input  logic signed [AMP_W-1:0] amp_q,
    input  logic [OUT_W-1:0]        code_q,
    input  nco_pkg::nco_state_e     state_q,
    input  logic [OUT_W-1:0]        nco_out
);

    int since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_q <= 0;
        else if (since_q < RST_LAT) since_q <= since_q + 1;
    end

    // R4: accumulator advances by the registered step
    a_r4_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
        acc_run |=> acc_q == ACC_W'($past(acc_q) + $past(inc_q)));

    // R8: run bit low clears the accumulator
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_run |=> acc_q == '0);

    // R2 and R3: both words gated off give a zero step
    a_r2_r3_gate_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_s && !center_en) |=> inc_q == '0);

    // R7: a positive amplitude never rounds into a negative code
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_q > 0) |=> !code_q[OUT_W-1]);

    // R10: output forced to zero through the first RST_LAT-1 edges
    a_r10_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q < RST_LAT - 1) |=> nco_out == '0);

    // R10: sequencer has reached RUN before the 11th edge
    a_r10_enter_run: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == RST_LAT - 1) |-> state_q == nco_pkg::ST_RUN);

endmodule

bind nco_dual_word nco_dual_word_chk #(
    .ACC_W(ACC_W), .AMP_W(AMP_W), .OUT_W(OUT_W), .RST_LAT(RST_LAT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_run   (acc_run),
    .center_en (center_en),
    .oe_s      (oe_s),
    .inc_q     (inc_q),
    .acc_q     (acc_q),
    .amp_q     (amp_q),
    .code_q    (code_q),
    .state_q   (state_q),
    .nco_out   (nco_out)
);

// File: tb/test_nco_dual_word.sv
`timescale 1ns/1ps
module test_nco_dual_word;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] center_word = '0;
    logic [47:0] offset_word = '0;
    logic        center_en = 1'b1;
    logic        offset_en = 1'b0;
    logic [1:0]  quad_sel = 2'd0;
    logic        acc_run = 1'b1;
    logic [13:0] nco_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nco_dual_word i_nco_dual_word (
        .clk         (clk),
        .rst_n       (rst_n),
        .center_word (center_word),
        .offset_word (offset_word),
        .center_en   (center_en),
        .offset_en   (offset_en),
        .quad_sel    (quad_sel),
        .acc_run     (acc_run),
        .nco_out     (nco_out)
    );

    // expected code from accumulator phase and quadrant (R4 R5 R6 R7)
    function automatic logic [13:0] exp_code(input logic [47:0] ph, input logic [1:0] q);
        int p;
        int qd;
        int idx;
        int mag;
        int amp;
        int c;
        p   = (int'(ph[47:36]) + int'(q) * 1024) % 4096;
        qd  = p / 1024;
        idx = (qd % 2 == 1) ? 1023 - (p % 1024) : (p % 1024);
        mag = $rtoi(32767.0 * $sin(2.0 * 3.14159265358979 * (real'(idx) + 0.5) / 4096.0) + 0.5);
        amp = (qd >= 2) ? -mag : mag;
        c   = (amp + 2) >>> 2;
        if (c > 8191) c = 8191;
        return 14'(c);
    endfunction

    task automatic chk(input string req, input logic [13:0] act, input logic [13:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: nco_out=%h expected %h", req, act, exp);
        end
    endtask

    // vector table: center word, offset word, {center_en, offset_en, quad}
    localparam logic [47:0] T_CF [6] = '{
        48'h0100_0000_0000, 48'h0100_0000_0000, 48'h4000_0000_0000,
        48'h2345_6789_ABCD, 48'h0123_4567_89AB, 48'h1000_0000_0000 };
    localparam logic [47:0] T_OF [6] = '{
        48'h0800_0000_0000, 48'h0400_0000_0000, 48'hC000_0000_0000,
        48'h0200_0000_0000, 48'h0000_0000_0000, 48'hFF00_0000_0000 };
    localparam logic [3:0] T_FL [6] = '{
        4'b1000, 4'b1101, 4'b1110, 4'b0111, 4'b1000, 4'b1100 };

    function automatic string vec_tag(input int v);
        case (v)
            0: return "R2 vector";
            1: return "R1 vector";
            2: return "R1 wrap vector";
            3: return "R3 vector";
            4: return "R4 vector";
            default: return "R1 R5 vector";
        endcase
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R10: reset state and settle window
        center_word = 48'h1000_0000_0000;
        repeat (3) @(negedge clk);
        chk("R10 in reset", nco_out, 14'h0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R10 after edge 10", nco_out, 14'h0);
        @(negedge clk);
        chk("R10 after edge 11", nco_out, exp_code(48'h0, 2'd0));
        @(negedge clk);
        chk("R10 after edge 12", nco_out, exp_code(48'h1000_0000_0000, 2'd0));

        // table walk: R1 R2 R3 R4 R5 R7 R8
        for (int v = 0; v < 6; v++) begin
            logic [47:0] step;
            logic [47:0] ph;
            center_word = T_CF[v];
            offset_word = T_OF[v];
            center_en   = T_FL[v][3];
            offset_en   = T_FL[v][2];
            quad_sel    = T_FL[v][1:0];
            step = (T_FL[v][3] ? T_CF[v] : 48'h0) + (T_FL[v][2] ? T_OF[v] : 48'h0);
            repeat (20) @(negedge clk);
            acc_run = 1'b0;
            @(negedge clk);
            acc_run = 1'b1;
            repeat (10) @(negedge clk);
            ph = '0;
            for (int j = 0; j < 8; j++) begin
                chk(vec_tag(v), nco_out, exp_code(ph, T_FL[v][1:0]));
                ph = ph + step;
                @(negedge clk);
            end
        end

        // R8: accumulator held at zero while the run bit is low
        center_word = 48'h1000_0000_0000;
        center_en = 1'b1;
        offset_en = 1'b0;
        quad_sel = 2'd2;
        acc_run = 1'b0;
        repeat (25) @(negedge clk);
        for (int j = 0; j < 3; j++) begin
            chk("R8 hold", nco_out, exp_code(48'h0, 2'd2));
            repeat (5) @(negedge clk);
        end

        // R9: offset enable latency of 14 edges
        center_word = 48'h0;
        offset_word = 48'h8000_0000_0000;
        quad_sel = 2'd0;
        repeat (20) @(negedge clk);
        acc_run = 1'b1;
        repeat (20) @(negedge clk);
        offset_en = 1'b1;
        repeat (13) @(negedge clk);
        chk("R9 before edge 14", nco_out, exp_code(48'h0, 2'd0));
        @(negedge clk);
        chk("R9 at edge 14", nco_out, exp_code(48'h8000_0000_0000, 2'd0));
        @(negedge clk);
        chk("R9 edge 15", nco_out, exp_code(48'h0, 2'd0));

        // R6: quadrant select latency of 12 edges, R7 saturation and minimum
        offset_en = 1'b0;
        repeat (20) @(negedge clk);
        acc_run = 1'b0;
        @(negedge clk);
        acc_run = 1'b1;
        repeat (20) @(negedge clk);
        quad_sel = 2'd1;
        repeat (11) @(negedge clk);
        chk("R6 before edge 12", nco_out, exp_code(48'h0, 2'd0));
        @(negedge clk);
        chk("R6 R7 saturate at edge 12", nco_out, 14'h1FFF);
        quad_sel = 2'd3;
        repeat (11) @(negedge clk);
        chk("R6 hold previous", nco_out, 14'h1FFF);
        @(negedge clk);
        chk("R6 R7 minimum code", nco_out, 14'h2000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule